// File: doc/BRIEF.md
# Multi-Address I2C Target Address Matcher

This block sits behind an I2C front end that has already turned the pins into clean one-cycle events: start, stop, a received address byte, and bus error. When an address byte arrives, the block compares its upper seven bits with ten programmable own-address slots. It also compares them with two special addresses: the general-call address 0x00 and the address-resolution address 0x61. Each special address has its own enable. On a hit it latches the result. The result holds the set of slots that hit, the lowest-numbered hit slot, the address the target is answering to, the transfer direction, and which kind of match happened. It also sets a sticky match flag, which can drive an interrupt.

Software reaches everything through a small byte-wide register port. The port has 16 offsets. Offsets 8 to 15 form a window onto the slot registers. A bank bit in the control register picks which slots appear in that window. In the default bank, the window shows slots 0 and 1. In the other bank, it shows slots 2 to 9. Register reads are registered and return data one cycle after the offset is presented.

Top module: `i2cm_target_match`

## Requirements
- R1: After a synchronous reset, every slot, the control register (offset 0) and the status register (offset 1) read zero, and `irq` is low.
- R2: The control register holds target enable (bit 0), general-call enable (bit 1), address-resolution enable (bit 2), interrupt enable (bit 3) and bank select (bit 7). When bank select is 0, window offsets 8 and 9 map to slots 0 and 1, and offsets 10 to 15 read 0 and ignore writes. When bank select is 1, offsets 8 to 15 map to slots 2 to 9. Slot words read back as written.
- R3: A slot matches when its bit 7 is 1 and its bits 6:0 equal bits 7:1 of the address byte, while the target is enabled. A match sets status bit 0 (sticky) and bit 2 (own match). The per-slot hit bits appear at offset 2, bits 6:0, for slots 0 to 6, and at offset 3, bits 2:0, for slots 7 to 9.
- R4: A slot with bit 7 clear never hits, including a slot rewritten to zero.
- R5: Offset 4 reports the index of the lowest-numbered hit slot. Offset 5 reports the address being answered: the slot address for an own match, 0x00 for a general call, 0x61 for address resolution, and 0 when nothing matched.
- R6: Address 0x00 sets status bit 3 only when general-call enable is set.
- R7: Address 0x61 sets status bit 4 only when address-resolution enable is set.
- R8: On a match, status bit 5 copies bit 0 of the address byte (1 means the target transmits).
- R9: A stop while a match is held sets status bit 1 (sticky). Writing 1 to status bit 0 or bit 1 clears that bit, and writing 0 leaves it unchanged.
- R10: `irq` is high exactly when status bit 0 and interrupt enable are both set.
- R11: While target enable is 0, address events change no status, hit, index or address state.
- R12: A bus-error event clears all status bits, hit bits, index and address.
- R13: The match result (status bits 2 to 5, hit bits, index, address) stays stable until the next start, stop, address event or bus error. A start or a stop clears it, and sticky bit 0 survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start | input | 1 | One-cycle start or repeated-start event |
| ev_stop | input | 1 | One-cycle stop event |
| ev_addr | input | 1 | One-cycle strobe: `addr_byte` is valid |
| addr_byte | input | 8 | Received address byte, bits 7:1 address, bit 0 read/write |
| ev_bus_err | input | 1 | One-cycle bus-error event |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for the offset presented in the previous cycle |
| irq | output | 1 | Match interrupt |

## Verification
The hardest state to reach from the ports is a held match that must survive address events. Such events could disturb it but should not. The bench first gets a real own-address match. It then clears target enable without issuing a start and sends a second, different address that would otherwise hit. It reads back the unchanged hit bits and status. Several slots share one address, one slot is enabled but rewritten to zero, and slots sit in both banks. This shows lowest-slot selection, the split hit vector and the bank window through the same register reads that software would use.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  // register offsets
  localparam logic [3:0] OFS_CTRL  = 4'h0;
  localparam logic [3:0] OFS_STAT  = 4'h1;
  localparam logic [3:0] OFS_HITLO = 4'h2;
  localparam logic [3:0] OFS_HITHI = 4'h3;
  localparam logic [3:0] OFS_SEL   = 4'h4;
  localparam logic [3:0] OFS_RESP  = 4'h5;
  // control bits
  localparam int CTL_EN   = 0;
  localparam int CTL_GC   = 1;
  localparam int CTL_ARP  = 2;
  localparam int CTL_IE   = 3;
  localparam int CTL_BANK = 7;
  // status bits
  localparam int ST_MATCH = 0;
  localparam int ST_STOP  = 1;
  localparam int ST_OWN   = 2;
  localparam int ST_GC    = 3;
  localparam int ST_ARP   = 4;
  localparam int ST_DIR   = 5;
  // number of hit bits in the low hit register
  localparam int HIT_LO_BITS = 7;
endpackage

// File: rtl/i2cm_slot_bank.sv
module i2cm_slot_bank #(
  parameter int NSLOT = 10,
  parameter int AW    = 7,
  localparam int IW   = $clog2(NSLOT),
  localparam int SW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IW-1:0]    widx,
  input  logic [SW-1:0]    wdata,
  input  logic [IW-1:0]    ridx,
  output logic [SW-1:0]    rdata,
  input  logic [AW-1:0]    cmp_addr,
  output logic [NSLOT-1:0] hit
);
  logic [SW-1:0] slot_q [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                          slot_q[g] <= '0;
      else if (we && widx == IW'(g))    slot_q[g] <= wdata;
    end
    // enable bit is the top bit of the slot word
    assign hit[g] = slot_q[g][SW-1] && (slot_q[g][AW-1:0] == cmp_addr);
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NSLOT; i++)
      if (ridx == IW'(i)) rdata = slot_q[i];
  end
endmodule

// File: rtl/i2cm_lowest.sv
module i2cm_lowest #(
  parameter int N   = 10,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) idx = IW'(i);
  end
endmodule

// File: rtl/i2cm_target_match.sv
module i2cm_target_match
  import i2cm_pkg::*;
#(
  parameter int         NSLOT       = 10,
  parameter int         BANK0_SLOTS = 2,
  parameter logic [6:0] GC_ADDR     = 7'h00,
  parameter logic [6:0] ARP_ADDR    = 7'h61
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_addr,
  input  logic [7:0] addr_byte,
  input  logic       ev_bus_err,
  input  logic       reg_we,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  localparam int AW   = 7;
  localparam int IW   = $clog2(NSLOT);
  localparam int HI_N = NSLOT - HIT_LO_BITS;

  // control
  logic ctrl_en, ctrl_gc, ctrl_arp, ctrl_ie, ctrl_bank;
  // status and captured match
  logic             st_match, st_stop, st_own, st_gc, st_arp, st_dir;
  logic [NSLOT-1:0] hit_q;
  logic [IW-1:0]    sel_q;
  logic [AW-1:0]    resp_q;

  // slot window decode
  logic          win_sel, slot_ok;
  logic [2:0]    woff;
  logic [IW-1:0] slot_idx;
  logic [7:0]    slot_rd;
  int            wi;

  assign win_sel = reg_addr[3];
  assign woff    = reg_addr[2:0];

  always_comb begin
    wi       = ctrl_bank ? int'(woff) + BANK0_SLOTS : int'(woff);
    slot_ok  = win_sel && (ctrl_bank ? (int'(woff) < NSLOT - BANK0_SLOTS)
                                     : (int'(woff) < BANK0_SLOTS));
    slot_idx = IW'(wi);
  end

  // compare path
  logic [AW-1:0]    cmp_addr;
  logic [NSLOT-1:0] hit_now;
  logic             own_any;
  logic [IW-1:0]    own_idx;
  logic             gc_hit, arp_hit, any_hit, addr_take;

  assign cmp_addr = addr_byte[7:1];

  i2cm_slot_bank #(.NSLOT(NSLOT), .AW(AW)) i_slots (
    .clk      (clk),
    .rst      (rst),
    .we       (reg_we && slot_ok),
    .widx     (slot_idx),
    .wdata    (reg_wdata),
    .ridx     (slot_idx),
    .rdata    (slot_rd),
    .cmp_addr (cmp_addr),
    .hit      (hit_now)
  );

  i2cm_lowest #(.N(NSLOT)) i_lowest (
    .req (hit_now),
    .any (own_any),
    .idx (own_idx)
  );

  assign gc_hit    = ctrl_gc  && (cmp_addr == GC_ADDR);
  assign arp_hit   = ctrl_arp && (cmp_addr == ARP_ADDR);
  assign any_hit   = own_any || gc_hit || arp_hit;
  assign addr_take = ev_addr && ctrl_en;

  wire stat_wr = reg_we && (reg_addr == OFS_STAT);

  // control register
  always_ff @(posedge clk) begin
    if (rst) begin
      {ctrl_en, ctrl_gc, ctrl_arp, ctrl_ie, ctrl_bank} <= '0;
    end else if (reg_we && reg_addr == OFS_CTRL) begin
      ctrl_en   <= reg_wdata[CTL_EN];
      ctrl_gc   <= reg_wdata[CTL_GC];
      ctrl_arp  <= reg_wdata[CTL_ARP];
      ctrl_ie   <= reg_wdata[CTL_IE];
      ctrl_bank <= reg_wdata[CTL_BANK];
    end
  end

  // sticky flags: bus error beats set, set beats write-one-to-clear
  always_ff @(posedge clk) begin
    if (rst || ev_bus_err) begin
      st_match <= 1'b0;
      st_stop  <= 1'b0;
    end else begin
      if (addr_take && any_hit)                   st_match <= 1'b1;
      else if (stat_wr && reg_wdata[ST_MATCH])    st_match <= 1'b0;
      if (ev_stop && (st_own || st_gc || st_arp)) st_stop  <= 1'b1;
      else if (stat_wr && reg_wdata[ST_STOP])     st_stop  <= 1'b0;
    end
  end

  // captured match result
  always_ff @(posedge clk) begin
    if (rst || ev_bus_err) begin
      {st_own, st_gc, st_arp, st_dir} <= '0;
      hit_q  <= '0;
      sel_q  <= '0;
      resp_q <= '0;
    end else if (addr_take) begin
      st_own <= own_any;
      st_gc  <= gc_hit;
      st_arp <= arp_hit;
      st_dir <= any_hit && addr_byte[0];
      hit_q  <= hit_now;
      sel_q  <= own_any ? own_idx : '0;
      resp_q <= own_any ? cmp_addr : gc_hit ? GC_ADDR : arp_hit ? ARP_ADDR : '0;
    end else if (ev_start || ev_stop) begin
      {st_own, st_gc, st_arp, st_dir} <= '0;
      hit_q  <= '0;
      sel_q  <= '0;
      resp_q <= '0;
    end
  end

  // split hit vector
  logic [7:0] hit_lo, hit_hi;
  always_comb begin
    hit_lo = '0;
    hit_hi = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (i < HIT_LO_BITS) hit_lo[i] = hit_q[i];
      else                 hit_hi[i - HIT_LO_BITS] = hit_q[i];
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (win_sel) begin
      reg_rdata <= slot_ok ? slot_rd : 8'h00;
    end else begin
      case (reg_addr)
        OFS_CTRL:  reg_rdata <= {ctrl_bank, 3'b000, ctrl_ie, ctrl_arp, ctrl_gc, ctrl_en};
        OFS_STAT:  reg_rdata <= {2'b00, st_dir, st_arp, st_gc, st_own, st_stop, st_match};
        OFS_HITLO: reg_rdata <= hit_lo;
        OFS_HITHI: reg_rdata <= hit_hi;
        OFS_SEL:   reg_rdata <= 8'(sel_q);
        OFS_RESP:  reg_rdata <= {1'b0, resp_q};
        default:   reg_rdata <= 8'h00;
      endcase
    end
  end

  assign irq = st_match && ctrl_ie;

  // ---------------- assertions ----------------
  assert_sel_is_hit_R5: assert property (@(posedge clk) disable iff (rst)
    st_own |-> hit_q[sel_q]);

  assert_own_flag_R3: assert property (@(posedge clk) disable iff (rst)
    st_own == (|hit_q));

  assert_bus_err_clears_R12: assert property (@(posedge clk) disable iff (rst)
    ev_bus_err |=> (!st_match && !st_stop && !st_own && !st_gc && !st_arp && hit_q == '0));

  assert_disabled_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (ev_addr && !ctrl_en && !ev_bus_err && !ev_start && !ev_stop && !reg_we)
    |=> ($stable(hit_q) && $stable(st_match) && $stable(resp_q)));

  assert_result_held_R13: assert property (@(posedge clk) disable iff (rst)
    (!ev_addr && !ev_start && !ev_stop && !ev_bus_err)
    |=> ($stable(sel_q) && $stable(st_dir) && $stable(hit_q)));

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> (st_match && ctrl_ie));
endmodule

// File: tb/test_i2cm_target_match.sv
module test_i2cm_target_match;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ev_start = 0, ev_stop = 0, ev_addr = 0, ev_bus_err = 0;
  logic [7:0] addr_byte = '0;
  logic       reg_we = 0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2cm_target_match i_i2cm_target_match (
    .clk(clk), .rst(rst), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_addr(ev_addr), .addr_byte(addr_byte), .ev_bus_err(ev_bus_err),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // byte, status, hit low, hit high, index, answered address
  localparam logic [47:0] VEC [8] = '{
    {8'h20, 8'h05, 8'h01, 8'h00, 8'h00, 8'h10},  // slot 0, write
    {8'h67, 8'h25, 8'h0C, 8'h00, 8'h02, 8'h33},  // slots 2,3 hit, slot 4 zeroed
    {8'h8A, 8'h05, 8'h00, 8'h01, 8'h07, 8'h45},  // slot 7 in high register
    {8'hA1, 8'h25, 8'h00, 8'h04, 8'h09, 8'h50},  // slot 9, read
    {8'h00, 8'h09, 8'h00, 8'h00, 8'h00, 8'h00},  // general call
    {8'hC3, 8'h31, 8'h00, 8'h00, 8'h00, 8'h61},  // address resolution, read
    {8'h44, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},  // slot 1 not enabled
    {8'hFE, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}   // no slot
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic p_start();
    @(negedge clk); ev_start = 1; @(negedge clk); ev_start = 0;
  endtask
  task automatic p_stop();
    @(negedge clk); ev_stop = 1; @(negedge clk); ev_stop = 0;
  endtask
  task automatic p_berr();
    @(negedge clk); ev_bus_err = 1; @(negedge clk); ev_bus_err = 0;
  endtask
  task automatic p_addr(input logic [7:0] b);
    @(negedge clk); addr_byte = b; ev_addr = 1; @(negedge clk); ev_addr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    rd(4'h0, v); chk("R1 ctrl", v, 8'h00);
    rd(4'h1, v); chk("R1 stat", v, 8'h00);
    rd(4'h8, v); chk("R1 slot0", v, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // program slots, bank 0 then bank 1
    wr(4'h0, 8'h0F);
    wr(4'h8, 8'h90);          // slot 0: 0x10 enabled
    wr(4'h9, 8'h22);          // slot 1: enable bit clear
    wr(4'hA, 8'hAA);          // unmapped in bank 0
    wr(4'h0, 8'h8F);
    wr(4'h8, 8'hB3);          // slot 2: 0x33
    wr(4'h9, 8'hB3);          // slot 3: 0x33
    wr(4'hA, 8'hB3);          // slot 4: 0x33 then zero
    wr(4'hA, 8'h00);
    wr(4'hD, 8'hC5);          // slot 7: 0x45
    wr(4'hF, 8'hD0);          // slot 9: 0x50

    // R2 bank window readback
    rd(4'h0, v); chk("R2 ctrl", v, 8'h8F);
    rd(4'h8, v); chk("R2 slot2", v, 8'hB3);
    rd(4'hA, v); chk("R2 slot4 zero R4", v, 8'h00);
    rd(4'hF, v); chk("R2 slot9", v, 8'hD0);
    wr(4'h0, 8'h0F);
    rd(4'h8, v); chk("R2 slot0", v, 8'h90);
    rd(4'h9, v); chk("R2 slot1", v, 8'h22);
    rd(4'hA, v); chk("R2 unmapped", v, 8'h00);

    // vector table: R3 R4 R5 R6 R7 R8 R10
    for (int k = 0; k < 8; k++) begin
      wr(4'h1, 8'h03);
      p_start();
      p_addr(VEC[k][47:40]);
      chk("R10 irq", {7'b0, irq}, {7'b0, VEC[k][32]});
      rd(4'h1, v); chk("R3 R6 R7 R8 stat", v, VEC[k][39:32]);
      rd(4'h2, v); chk("R3 R4 hitlo", v, VEC[k][31:24]);
      rd(4'h3, v); chk("R3 hithi", v, VEC[k][23:16]);
      rd(4'h4, v); chk("R5 index", v, VEC[k][15:8]);
      rd(4'h5, v); chk("R5 resp", v, VEC[k][7:0]);
      p_stop();
    end

    // R9 stop sticky and write-one-to-clear
    wr(4'h1, 8'h03);
    p_start(); p_addr(8'h20); p_stop();
    rd(4'h1, v); chk("R9 stop set, R13 cleared", v, 8'h03);
    wr(4'h1, 8'h01);
    rd(4'h1, v); chk("R9 clear match only", v, 8'h02);
    wr(4'h1, 8'h00);
    rd(4'h1, v); chk("R9 write zero no effect", v, 8'h02);
    wr(4'h1, 8'h02);
    rd(4'h1, v); chk("R9 clear stop", v, 8'h00);

    // R13 repeated start clears result, sticky survives
    p_start(); p_addr(8'h67); p_start();
    rd(4'h1, v); chk("R13 after restart", v, 8'h01);
    rd(4'h4, v); chk("R13 index cleared", v, 8'h00);
    rd(4'h2, v); chk("R13 hits cleared", v, 8'h00);

    // R10 interrupt enable gates irq
    wr(4'h0, 8'h07);
    wr(4'h1, 8'h03);
    p_start(); p_addr(8'h20);
    chk("R10 irq masked", {7'b0, irq}, 8'h00);
    rd(4'h1, v); chk("R10 stat still set", v, 8'h05);

    // R12 bus error clears everything
    wr(4'h0, 8'h0F);
    p_berr();
    rd(4'h1, v); chk("R12 stat", v, 8'h00);
    rd(4'h2, v); chk("R12 hitlo", v, 8'h00);
    rd(4'h5, v); chk("R12 resp", v, 8'h00);
    chk("R12 irq", {7'b0, irq}, 8'h00);

    // R6 general call off
    wr(4'h0, 8'h09);
    p_start(); p_addr(8'h00);
    rd(4'h1, v); chk("R6 gc disabled", v, 8'h00);
    // R7 address resolution off
    p_start(); p_addr(8'hC3);
    rd(4'h1, v); chk("R7 arp disabled", v, 8'h00);

    // R11 disabled target keeps held match untouched
    wr(4'h0, 8'h0F);
    p_start(); p_addr(8'h20);
    wr(4'h0, 8'h08);
    p_addr(8'h67);
    rd(4'h1, v); chk("R11 stat kept", v, 8'h05);
    rd(4'h2, v); chk("R11 hits kept", v, 8'h01);
    rd(4'h5, v); chk("R11 resp kept", v, 8'h10);
    wr(4'h1, 8'h01);
    p_addr(8'h20);
    rd(4'h1, v); chk("R11 no new match", v, 8'h04);
    chk("R11 irq", {7'b0, irq}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule